// File: doc/BRIEF.md
# Buffered Serial Transmitter with Status Flags

This block is the transmit half of one asynchronous serial channel. A host pushes bytes into a first-in first-out store, and a shift register sends each one on a single line. Each frame is a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two stop bits. Bit timing comes from an oversampling strobe supplied from outside. One bit spans either 16 or 8 strobe pulses, chosen by a select input.

Two status flags report different things. One shows that the store is empty. The other shows that the store and the shifter are both idle, so the last stop bit has left the line. A level-triggered interrupt fires when draining takes the fill level below a programmable threshold, and again when the store runs dry. An optional clear-to-send gate holds back new frames while the far end signals that it is not ready.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` and `tx_empty` are 1, `tx_irq` and `ovf_sticky` are 0, and `fifo_level` is 0.
- R2: The store holds up to DEPTH bytes, and `fifo_level` reports its fill. A write strobe seen while the store is full is dropped, even if a byte leaves in the same cycle. The drop sets `ovf_sticky`, which stays 1 until reset.
- R3: `hold_empty` is 1 exactly when `fifo_level` is 0.
- R4: `tx_empty` is 1 exactly when the store is empty and no frame is being sent.
- R5: The line idles at 1. A frame is a 0 start bit, then N data bits with the least significant bit first, where N = 5 + `data_bits` (code 0..3). When `parity_en` is 1, a parity bit follows. Parity is even when `parity_odd` is 0, meaning the data ones plus the parity bit give an even count, and odd otherwise. The frame ends with one stop bit of value 1, or two when `two_stop` is 1.
- R6: Each bit of a frame lasts 16 `tick` pulses when `os_sel` is 0 and 8 pulses when `os_sel` is 1.
- R7: In any clock cycle where the shifter is idle, the store is not empty and the gate allows it, the oldest byte is taken. Its start bit appears on `txd` after that clock edge. The next byte can be taken in the cycle after the previous frame's last stop bit ends.
- R8: While `cts_auto_en` is 1 and `cts_n` is 1, no new frame starts and the store keeps its bytes. A frame already in progress completes in full.
- R9: An internal pending flag is set when a clock edge moves the fill level from at least `trig_lvl` to below it, or from nonzero to zero. Otherwise, any write strobe clears the flag. A set takes priority over a clear in the same cycle.
- R10: `tx_irq` is the pending flag ANDed with `thr_irq_en`. Clearing the enable hides the flag but does not discard it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to enqueue |
| tick | input | 1 | Oversampling strobe |
| os_sel | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| data_bits | input | 2 | Data length code, length = 5 + code |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | Send two stop bits |
| trig_lvl | input | $clog2(DEPTH+1) | Interrupt fill threshold |
| thr_irq_en | input | 1 | Interrupt enable |
| cts_auto_en | input | 1 | Enable the clear-to-send gate |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Store is empty |
| tx_empty | output | 1 | Store and shifter are both empty |
| tx_irq | output | 1 | Transmit interrupt |
| ovf_sticky | output | 1 | A write was dropped because the store was full |
| fifo_level | output | $clog2(DEPTH+1) | Store fill level |

## Verification
The bench builds the block with DEPTH=8, so `fifo_level` is four bits wide. This lets short write bursts reach the full store, the dropped-write path and every threshold value from 0 to DEPTH. The bench changes the tick spacing between 1 and 3 clocks, together with both oversampling ratios. This brings frames that take from about 60 to over 400 cycles, along with every length from 7 to 12 bits, into a short run. A behavioural queue model is compared with every output on each clock. This covers the exact edge of each start, bit change and interrupt, including a gate closed in the middle of a frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int FRAME_MAX = 12;
  localparam int CNT_W     = 4;

  typedef struct packed {
    logic [1:0] dbits;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic       os8;
  } frame_cfg_t;

  function automatic int data_len(input frame_cfg_t c);
    return 5 + int'(c.dbits);
  endfunction

  // Total frame length in bits: start + data + parity + stop(s)
  function automatic logic [CNT_W-1:0] frame_len(input frame_cfg_t c);
    int n;
    n = 1 + data_len(c) + (c.par_en ? 1 : 0) + (c.two_stop ? 2 : 1);
    return CNT_W'(n);
  endfunction

  // Index of the final tick within one bit period
  function automatic logic [CNT_W-1:0] bit_last(input logic os8);
    return os8 ? CNT_W'(7) : CNT_W'(15);
  endfunction

  // Frame image, bit 0 goes out first; unused upper bits stay 1 (stop level)
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] d,
                                                      input frame_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    logic p;
    int nd;
    f    = '1;
    f[0] = 1'b0;
    nd   = data_len(c);
    p    = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) begin
        f[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (c.par_en) f[nd+1] = p ^ c.par_odd;
    return f;
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign dout  = mem[rd_ptr];
  assign level = count;
  assign full  = (count == LVL_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       start,
  input  logic [7:0] din,
  output logic       busy,
  output logic       txd
);

  logic [FRAME_MAX-1:0] sr;
  logic [CNT_W-1:0]     bits_left;
  logic [CNT_W-1:0]     tcnt;
  logic                 busy_q;
  logic                 bit_done;
  logic                 last_bit;

  assign bit_done = busy_q && tick && (tcnt == bit_last(cfg.os8));
  assign last_bit = (bits_left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      busy_q    <= 1'b0;
    end else if (start) begin
      sr        <= build_frame(din, cfg);
      bits_left <= frame_len(cfg);
      tcnt      <= '0;
      busy_q    <= 1'b1;
    end else if (bit_done) begin
      tcnt      <= '0;
      sr        <= {1'b1, sr[FRAME_MAX-1:1]};
      bits_left <= bits_left - 1'b1;
      if (last_bit) busy_q <= 1'b0;
    end else if (busy_q && tick) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sr[0] : 1'b1;

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             push,
  input  logic             pop,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] trig,
  input  logic             irq_en,
  input  logic             busy,
  input  logic             ovf_evt,
  output logic             hold_empty,
  output logic             tx_empty,
  output logic             tx_irq,
  output logic             ovf_sticky
);

  logic [LVL_W-1:0] level_nxt;
  logic             cross_trig;
  logic             reach_empty;
  logic             irq_set;
  logic             pend_q;
  logic             ovf_q;

  assign level_nxt   = level + LVL_W'(push) - LVL_W'(pop);
  assign cross_trig  = (level >= trig) && (level_nxt < trig);
  assign reach_empty = (level != '0) && (level_nxt == '0);
  assign irq_set     = cross_trig || reach_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (irq_set)    pend_q <= 1'b1;
      else if (wr_en) pend_q <= 1'b0;
      if (ovf_evt)    ovf_q  <= 1'b1;
    end
  end

  assign hold_empty = (level == '0);
  assign tx_empty   = hold_empty && !busy;
  assign tx_irq     = pend_q && irq_en;
  assign ovf_sticky = ovf_q;

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             tick,
  input  logic             os_sel,
  input  logic [1:0]       data_bits,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             two_stop,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic             thr_irq_en,
  input  logic             cts_auto_en,
  input  logic             cts_n,
  output logic             txd,
  output logic             hold_empty,
  output logic             tx_empty,
  output logic             tx_irq,
  output logic             ovf_sticky,
  output logic [LVL_W-1:0] fifo_level
);

  frame_cfg_t       cfg;
  logic             fifo_full, fifo_empty;
  logic [7:0]       head;
  logic             push_ok, ovf_evt, cts_hold, pop_evt, shf_busy;

  assign cfg = '{dbits: data_bits, par_en: parity_en, par_odd: parity_odd,
                 two_stop: two_stop, os8: os_sel};

  assign push_ok  = wr_en && !fifo_full;
  assign ovf_evt  = wr_en && fifo_full;
  assign cts_hold = cts_auto_en && cts_n;
  assign pop_evt  = !shf_busy && !fifo_empty && !cts_hold;

  sertx_fifo #(.DEPTH(DEPTH), .DW(8)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .din(wr_data), .pop(pop_evt),
    .dout(head), .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
  );

  sertx_shifter shf_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .start(pop_evt),
    .din(head), .busy(shf_busy), .txd(txd)
  );

  sertx_flags #(.LVL_W(LVL_W)) flg_i (
    .clk(clk), .rst_n(rst_n), .level(fifo_level), .push(push_ok), .pop(pop_evt),
    .wr_en(wr_en), .trig(trig_lvl), .irq_en(thr_irq_en), .busy(shf_busy),
    .ovf_evt(ovf_evt), .hold_empty(hold_empty), .tx_empty(tx_empty),
    .tx_irq(tx_irq), .ovf_sticky(ovf_sticky)
  );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             cts_auto_en,
  input logic             cts_n,
  input logic             thr_irq_en,
  input logic             txd,
  input logic             hold_empty,
  input logic             tx_empty,
  input logic             tx_irq,
  input logic             ovf_sticky,
  input logic [LVL_W-1:0] fifo_level,
  input logic             pop_evt,
  input logic             shf_busy
);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R2
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky);

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_level == LVL_W'(DEPTH)) |=> ovf_sticky);

  // R4
  empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  // R5
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shf_busy |-> txd);

  // R8
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> !(cts_auto_en && cts_n));

  // R7
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (shf_busy && !txd));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> thr_irq_en);

endmodule

bind sertx_core sertx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cts_auto_en(cts_auto_en),
  .cts_n(cts_n), .thr_irq_en(thr_irq_en), .txd(txd), .hold_empty(hold_empty),
  .tx_empty(tx_empty), .tx_irq(tx_irq), .ovf_sticky(ovf_sticky),
  .fifo_level(fifo_level), .pop_evt(pop_evt), .shf_busy(shf_busy)
);

// File: tb/sertx_core_tb.sv
`timescale 1ns/1ps
module sertx_core_tb_top;

  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          tick = 1'b0;
  logic          os_sel = 1'b0;
  logic [1:0]    data_bits = 2'd3;
  logic          parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
  logic [LW-1:0] trig_lvl = '0;
  logic          thr_irq_en = 1'b0, cts_auto_en = 1'b0, cts_n = 1'b0;
  logic          txd, hold_empty, tx_empty, tx_irq, ovf_sticky;
  logic [LW-1:0] fifo_level;

  int checks = 0, fails = 0, cycles = 0, tdiv = 1, tphase = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sertx_core #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .os_sel(os_sel), .data_bits(data_bits), .parity_en(parity_en),
    .parity_odd(parity_odd), .two_stop(two_stop), .trig_lvl(trig_lvl),
    .thr_irq_en(thr_irq_en), .cts_auto_en(cts_auto_en), .cts_n(cts_n),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .tx_irq(tx_irq),
    .ovf_sticky(ovf_sticky), .fifo_level(fifo_level)
  );

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  bit         mbits[$];
  int         mcnt, lb, la;
  bit         mbusy, movf, mpend, wok, ld;
  logic [7:0] mb;

  task automatic make_bits(input logic [7:0] d);
    bit par = 0;
    mbits.delete();
    mbits.push_back(1'b0);
    for (int i = 0; i < 5 + int'(data_bits); i++) begin
      mbits.push_back(d[i]);
      par ^= d[i];
    end
    if (parity_en) mbits.push_back(par ^ parity_odd);
    mbits.push_back(1'b1);
    if (two_stop) mbits.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mbits.delete();
      mbusy = 0; mcnt = 0; movf = 0; mpend = 0;
    end else begin
      lb  = mq.size();
      wok = wr_en && (lb < DEPTH);
      if (wr_en && !wok) movf = 1;
      ld = !mbusy && (lb > 0) && (!cts_auto_en || !cts_n);
      if (mbusy && tick) begin
        if (mcnt == (os_sel ? 8 : 16) - 1) begin
          mcnt = 0;
          void'(mbits.pop_front());
          if (mbits.size() == 0) mbusy = 0;
        end else mcnt++;
      end
      if (ld) begin
        mb = mq.pop_front();
        make_bits(mb);
        mbusy = 1; mcnt = 0;
      end
      if (wok) mq.push_back(wr_data);
      la = mq.size();
      if ((lb >= int'(trig_lvl) && la < int'(trig_lvl)) || (lb != 0 && la == 0))
        mpend = 1;
      else if (wr_en) mpend = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // every-cycle comparison, away from the clock edges
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R5 R6 R7 txd", int'(txd), mbusy ? int'(mbits[0]) : 1);
      check("R2 fifo_level", int'(fifo_level), mq.size());
      check("R3 hold_empty", int'(hold_empty), int'(mq.size() == 0));
      check("R4 tx_empty", int'(tx_empty), int'(mq.size() == 0 && !mbusy));
      check("R9 R10 tx_irq", int'(tx_irq), int'(mpend && thr_irq_en));
      check("R2 ovf_sticky", int'(ovf_sticky), int'(movf));
    end
  end

  // oversampling strobe
  always @(negedge clk) begin
    tphase = (tphase + 1 >= tdiv) ? 0 : tphase + 1;
    tick <= (tphase == 0);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic push_bytes(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      wr_en   = 1'b1;
      wr_data = seed + 8'(i * 37);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic spin(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    spin(4);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 txd", int'(txd), 1);
    check("R1 hold_empty", int'(hold_empty), 1);
    check("R1 tx_empty", int'(tx_empty), 1);
    check("R1 tx_irq", int'(tx_irq), 0);
    check("R1 ovf_sticky", int'(ovf_sticky), 0);
    check("R1 fifo_level", int'(fifo_level), 0);
    @(negedge clk);

    // R5 R6 R7: 8N1, 16x, tick every clock
    tdiv = 1; thr_irq_en = 1'b1; trig_lvl = LW'(2);
    push_bytes(3, 8'hA5);
    wait_idle();

    // R5 R6: 5 bits, even parity, 2 stops, 8x, tick every 3 clocks
    tdiv = 3; os_sel = 1'b1; data_bits = 2'd0; parity_en = 1'b1; two_stop = 1'b1;
    push_bytes(4, 8'h3C);
    wait_idle();

    // R5: 7 bits, odd parity, 1 stop, 16x, tick every 2 clocks
    tdiv = 2; os_sel = 1'b0; data_bits = 2'd2; parity_odd = 1'b1; two_stop = 1'b0;
    push_bytes(2, 8'h5B);
    wait_idle();

    // R8: gate closed holds everything
    cts_auto_en = 1'b1; cts_n = 1'b1; tdiv = 1; os_sel = 1'b1;
    data_bits = 2'd1; parity_en = 1'b0; parity_odd = 1'b0;
    push_bytes(3, 8'h11);
    spin(200); #1;
    check("R8 level held", int'(fifo_level), 3);
    check("R8 line idle", int'(txd), 1);
    @(negedge clk);

    // R2: fill and overflow while gated
    push_bytes(DEPTH - 3 + 2, 8'h70);
    #1;
    check("R2 full level", int'(fifo_level), DEPTH);
    check("R2 overflow sticky", int'(ovf_sticky), 1);
    @(negedge clk);

    // R8: open gate, then close it in mid-frame; frame completes, next withheld
    trig_lvl = LW'(5);
    cts_n = 1'b0;
    while (txd) @(negedge clk);
    spin(20);
    cts_n = 1'b1;
    spin(300); #1;
    check("R8 one frame sent", int'(fifo_level), DEPTH - 1);
    check("R8 line idle after frame", int'(txd), 1);
    check("R4 not empty while gated", int'(tx_empty), 0);
    @(negedge clk);

    // R9 R10: drain with interrupt masked, then unmask
    thr_irq_en = 1'b0;
    cts_n = 1'b0;
    wait_idle();
    #1;
    check("R10 masked", int'(tx_irq), 0);
    @(negedge clk);
    thr_irq_en = 1'b1;
    #1;
    check("R10 pending kept", int'(tx_irq), 1);
    @(negedge clk);
    // R9: a write clears the pending flag
    push_bytes(1, 8'hE7);
    #1;
    check("R9 cleared by write", int'(tx_irq), 0);
    wait_idle();
    #1;
    check("R9 set on empty", int'(tx_irq), 1);
    @(negedge clk);

    // R9: threshold 0 only fires on empty; 6 bits even parity
    cts_auto_en = 1'b0; trig_lvl = '0; data_bits = 2'd1; parity_en = 1'b1;
    os_sel = 1'b0; tdiv = 1;
    push_bytes(DEPTH, 8'h0F);
    wait_idle();

    // R9: threshold DEPTH
    trig_lvl = LW'(DEPTH); data_bits = 2'd3; two_stop = 1'b1; os_sel = 1'b1;
    push_bytes(DEPTH, 8'hC3);
    wait_idle();

    finish_run();
  end

endmodule